// File: doc/BRIEF.md
# Relational and Overflow Flag Unit

This block is a flag-setting arithmetic stage for an integer datapath. It accepts two operands and a two-bit operation select: add, subtract, signed compare or unsigned compare. It registers a result word and six condition flags. The relational outcome is held as three separate one-hot flags: less-than, greater-than and equal. A carry flag is kept apart from them. Overflow is recorded twice. One flag covers only the latest add or subtract. A second, summary flag stays set until an explicit clear input drops it.

Downstream logic reads the flags in two ways. It can take the whole six-bit vector from the read port. It can also ask whether one chosen flag matches a sense bit, which is how a conditional branch tests one condition. The signed and unsigned compares share the subtract path and differ only in how the ordering is derived from it. A parameter can swap that derivation for dedicated comparators.

Top module: `cmpflag_unit`

## Requirements
- R1: With op_sel = 0 (add) and op_valid high, the cycle after the clock edge shows result = (a + b) mod 2^WIDTH, carry = the unsigned carry-out, and ov = 1 exactly when two operands of equal sign give a sum of the other sign.
- R2: With op_sel = 1 (subtract), result = (a - b) mod 2^WIDTH, carry = 1 exactly when a >= b unsigned (not-borrow), and ov = signed overflow of the difference.
- R3: After an add or subtract, exactly one of LT, GT, EQ is set, and it gives the signed comparison of the new result with zero.
- R4: With op_sel = 2 (signed compare), exactly one of LT, GT, EQ is set from the two's-complement order of a against b. Carry and ov keep their previous values, and result takes a - b.
- R5: With op_sel = 3 (unsigned compare), the relational flags follow the unsigned order of a against b. All else matches R4.
- R6: The summary flag sov becomes 1 after any add or subtract that sets ov. It then stays 1 through later operations that do not overflow.
- R7: sov_clear high for one cycle makes sov 0 on the next cycle. If an add or subtract that overflows is accepted in the same cycle, sov is 1 instead.
- R8: While op_valid is low, result and all flags hold their values whatever the operands and op_sel do. Only sov_clear may act.
- R9: The flag port packs bit 0 = LT, bit 1 = GT, bit 2 = EQ, bit 3 = carry, bit 4 = ov, bit 5 = sov. After reset the vector is 6'b000100 and result is 0.
- R10: br_taken is combinational. It is 1 when flag bit br_sel equals br_sense. Indices 6 and 7 read as a flag value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op_sel | input | 2 | 0 add, 1 subtract, 2 signed compare, 3 unsigned compare |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| sov_clear | input | 1 | Clear the summary overflow flag |
| result | output | WIDTH | Registered arithmetic result |
| flags | output | 6 | Flag read port, layout per R9 |
| br_sel | input | 3 | Flag index for the branch test |
| br_sense | input | 1 | Flag value that makes the branch taken |
| br_taken | output | 1 | Branch condition outcome |

## Verification
The result and every flag are due exactly one clock edge after the operation is accepted. The bench drives inputs on the falling edge and drops op_valid on the next falling edge. It compares result and flags at that point, so each check covers exactly one accepted operation. The branch outcome has no register in its path. It is checked a nanosecond after br_sel and br_sense change, with op_valid held low so the flags cannot move under it. The summary-flag clear is due on the same single-edge schedule and is checked on the falling edge that follows it.

// File: rtl/flagcmp_pkg.sv
package flagcmp_pkg;
   typedef enum logic [1:0] {
      OP_ADD  = 2'd0,
      OP_SUB  = 2'd1,
      OP_SCMP = 2'd2,
      OP_UCMP = 2'd3
   } op_e;

   localparam int FLAG_CNT = 6;
   localparam int FL_LT    = 0;
   localparam int FL_GT    = 1;
   localparam int FL_EQ    = 2;
   localparam int FL_CARRY = 3;
   localparam int FL_OV    = 4;
   localparam int FL_SOV   = 5;
   localparam int SEL_W    = 3;
endpackage

// File: rtl/flagcmp_addsub.sv
module flagcmp_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             carry,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   ext;

   always_comb begin
      b_eff = sub ? ~b : b;
      ext   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
      sum   = ext[WIDTH-1:0];
      carry = ext[WIDTH];
      ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   end
endmodule

// File: rtl/flagcmp_relate.sv
module flagcmp_relate #(
   parameter int WIDTH   = 32,
   parameter bit USE_SUB = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] diff,
   input  logic             sub_carry,
   input  logic             sub_ovf,
   output logic             lt,
   output logic             gt,
   output logic             eq
);
   localparam int MSB = WIDTH - 1;

   generate
      if (USE_SUB) begin : g_from_sub
         always_comb begin
            eq = (a == b);
            lt = is_signed ? (diff[MSB] ^ sub_ovf) : ~sub_carry;
            gt = ~lt & ~eq;
         end
      end else begin : g_direct
         always_comb begin
            eq = (a == b);
            lt = is_signed ? ($signed(a) < $signed(b)) : (a < b);
            gt = ~lt & ~eq;
         end
      end
   endgenerate
endmodule

// File: rtl/flagcmp_flagreg.sv
module flagcmp_flagreg
   import flagcmp_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_rel,
   input  logic                load_arith,
   input  logic [2:0]          rel_in,
   input  logic                carry_in,
   input  logic                ov_in,
   input  logic                sov_clear,
   output logic [FLAG_CNT-1:0] flags_q
);
   logic [2:0] rel_q;
   logic       carry_q;
   logic       ov_q;
   logic       sov_q;
   logic       sov_d;

   always_comb begin
      if (load_arith && ov_in) sov_d = 1'b1;
      else if (sov_clear)      sov_d = 1'b0;
      else                     sov_d = sov_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q   <= 3'b100;
         carry_q <= 1'b0;
         ov_q    <= 1'b0;
         sov_q   <= 1'b0;
      end else begin
         if (load_rel) rel_q <= rel_in;
         if (load_arith) begin
            carry_q <= carry_in;
            ov_q    <= ov_in;
         end
         sov_q <= sov_d;
      end
   end

   assign flags_q = {sov_q, ov_q, carry_q, rel_q};
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
   import flagcmp_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter bit REL_FROM_SUB = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [1:0]          op_sel,
   input  logic [WIDTH-1:0]    opnd_a,
   input  logic [WIDTH-1:0]    opnd_b,
   input  logic                sov_clear,
   output logic [WIDTH-1:0]    result,
   output logic [FLAG_CNT-1:0] flags,
   input  logic [SEL_W-1:0]    br_sel,
   input  logic                br_sense,
   output logic                br_taken
);
   localparam int MSB     = WIDTH - 1;
   localparam int PAD_CNT = (1 << SEL_W) - FLAG_CNT;

   if (WIDTH < 2) begin : g_bad_width
      $error("cmpflag_unit: WIDTH must be at least 2");
   end
   if (PAD_CNT < 0) begin : g_bad_sel
      $error("cmpflag_unit: SEL_W too narrow for flag count");
   end

   op_e              op;
   logic             is_arith;
   logic [WIDTH-1:0] sum;
   logic             carry;
   logic             ovf;
   logic             cmp_lt, cmp_gt, cmp_eq;
   logic [2:0]       rel;
   logic [WIDTH-1:0] result_q;

   assign op       = op_e'(op_sel);
   assign is_arith = (op == OP_ADD) || (op == OP_SUB);

   flagcmp_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a     (opnd_a),
      .b     (opnd_b),
      .sub   (op != OP_ADD),
      .sum   (sum),
      .carry (carry),
      .ovf   (ovf)
   );

   flagcmp_relate #(.WIDTH(WIDTH), .USE_SUB(REL_FROM_SUB)) u_relate (
      .a         (opnd_a),
      .b         (opnd_b),
      .is_signed (op == OP_SCMP),
      .diff      (sum),
      .sub_carry (carry),
      .sub_ovf   (ovf),
      .lt        (cmp_lt),
      .gt        (cmp_gt),
      .eq        (cmp_eq)
   );

   always_comb begin
      if (is_arith) begin
         rel[FL_LT] = sum[MSB];
         rel[FL_EQ] = (sum == '0);
         rel[FL_GT] = ~sum[MSB] && (sum != '0);
      end else begin
         rel[FL_LT] = cmp_lt;
         rel[FL_GT] = cmp_gt;
         rel[FL_EQ] = cmp_eq;
      end
   end

   flagcmp_flagreg u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_rel   (op_valid),
      .load_arith (op_valid && is_arith),
      .rel_in     (rel),
      .carry_in   (carry),
      .ov_in      (ovf),
      .sov_clear  (sov_clear),
      .flags_q    (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        result_q <= '0;
      else if (op_valid) result_q <= sum;
   end
   assign result = result_q;

   logic [(1<<SEL_W)-1:0] flag_ext;
   generate
      if (PAD_CNT > 0) begin : g_pad
         assign flag_ext = {{PAD_CNT{1'b0}}, flags};
      end else begin : g_nopad
         assign flag_ext = flags;
      end
   endgenerate

   assign br_taken = (flag_ext[br_sel] == br_sense);
endmodule

// File: rtl/flagcmp_checker.sv
module flagcmp_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       op_valid,
   input logic [1:0] op_sel,
   input logic       sov_clear,
   input logic [5:0] flags
);
   AST_REL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flags[2:0]) == 1); // R3

   AST_CMP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_sel[1] |=> $stable(flags[3]) && $stable(flags[4])); // R4

   AST_OV_SETS_SOV: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_sel[1] |=> (!flags[4] || flags[5])); // R6

   AST_SOV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flags[5] && !sov_clear |=> flags[5]); // R6

   AST_SOV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      sov_clear && !op_valid |=> !flags[5]); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid && !sov_clear |=> $stable(flags)); // R8
endmodule

bind cmpflag_unit flagcmp_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_sel    (op_sel),
   .sov_clear (sov_clear),
   .flags     (flags)
);

// File: tb/sim_cmpflag_unit.sv
`timescale 1ns/1ps
module sim_cmpflag_unit;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [1:0]   op_sel = 2'd0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic         sov_clear = 1'b0;
   logic [W-1:0] result;
   logic [5:0]   flags;
   logic [2:0]   br_sel = 3'd0;
   logic         br_sense = 1'b0;
   logic         br_taken;

   int total = 0;
   int fails = 0;
   bit done = 0;

   logic [W-1:0] m_res = '0;
   logic [5:0]   m_flags = 6'b000100;

   always #10 clk = ~clk;

   cmpflag_unit #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .sov_clear(sov_clear),
      .result(result), .flags(flags), .br_sel(br_sel),
      .br_sense(br_sense), .br_taken(br_taken)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] rel_of(input logic lt, input logic eq);
      return {eq, ~lt & ~eq, lt};
   endfunction

   task automatic apply(input logic [1:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic valid, input logic clr);
      logic [W:0] s;
      logic       ov;
      logic       arith;
      string      tag;
      @(negedge clk);
      op_valid = valid; op_sel = op; opnd_a = a; opnd_b = b; sov_clear = clr;
      @(negedge clk);
      op_valid = 1'b0; sov_clear = 1'b0;
      arith = (op[1] == 1'b0);
      ov = 1'b0;
      if (valid) begin
         case (op)
            2'd0: begin
               s = {1'b0, a} + {1'b0, b};
               m_res = s[W-1:0];
               ov = (a[W-1] == b[W-1]) && (m_res[W-1] != a[W-1]);
               m_flags[3] = s[W];
               m_flags[4] = ov;
               m_flags[2:0] = rel_of(m_res[W-1], m_res == 0);
            end
            2'd1: begin
               m_res = a - b;
               ov = (a[W-1] != b[W-1]) && (m_res[W-1] != a[W-1]);
               m_flags[3] = (a >= b);
               m_flags[4] = ov;
               m_flags[2:0] = rel_of(m_res[W-1], m_res == 0);
            end
            2'd2: begin
               m_res = a - b;
               m_flags[2:0] = rel_of($signed(a) < $signed(b), a == b);
            end
            default: begin
               m_res = a - b;
               m_flags[2:0] = rel_of(a < b, a == b);
            end
         endcase
      end
      if (valid && arith && ov) m_flags[5] = 1'b1;
      else if (clr)             m_flags[5] = 1'b0;
      tag = !valid ? "R8" : (op == 2'd0) ? "R1" : (op == 2'd1) ? "R2" :
            (op == 2'd2) ? "R4" : "R5";
      check(tag, {24'd0, result}, {24'd0, m_res});
      check(tag, {30'd0, flags[4:3]}, {30'd0, m_flags[4:3]});
      check((valid && arith) ? "R3" : tag, {29'd0, flags[2:0]}, {29'd0, m_flags[2:0]});
      check(clr ? "R7" : "R6", {31'd0, flags[5]}, {31'd0, m_flags[5]});
   endtask

   task automatic branch_sweep();
      for (int sel = 0; sel < 8; sel++) begin
         for (int sn = 0; sn < 2; sn++) begin
            br_sel = 3'(sel); br_sense = sn[0];
            #1;
            // R10: taken when the chosen flag equals the sense bit
            check("R10", {31'd0, br_taken},
                  {31'd0, ((sel < 6) ? m_flags[sel] : 1'b0) == sn[0]});
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset values
      check("R9", {24'd0, result}, 32'd0);
      check("R9", {26'd0, flags}, 32'b000100);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R4 R5: near-exhaustive sweep on a coarse operand grid
      for (int i = 0; i < 52; i++) begin
         for (int j = 0; j < 52; j++) begin
            for (int op = 0; op < 4; op++) begin
               apply(2'(op), 8'(i * 5), 8'(j * 5), 1'b1, 1'b0);
            end
         end
      end
      // boundary operands around the sign change
      foreach (m_res[k]) begin end
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++) begin
            logic [7:0] e [6];
            e = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};
            for (int op = 0; op < 4; op++) apply(2'(op), e[i], e[j], 1'b1, 1'b0);
         end
      end

      // R7: clear with nothing else pending
      apply(2'd0, 8'h7F, 8'h01, 1'b1, 1'b0);
      apply(2'd0, 8'h00, 8'h00, 1'b0, 1'b1);
      // R7: clear loses to a simultaneous overflow
      apply(2'd1, 8'h80, 8'h01, 1'b1, 1'b1);
      // R7: clear with a non-overflowing add
      apply(2'd0, 8'h01, 8'h01, 1'b1, 1'b1);
      // R6: sticky through a clean op
      apply(2'd0, 8'h80, 8'h80, 1'b1, 1'b0);
      apply(2'd0, 8'h02, 8'h03, 1'b1, 1'b0);
      // R8: idle cycles with wandering inputs
      for (int k = 0; k < 8; k++) apply(2'(k), 8'(k * 37), 8'(k * 91), 1'b0, 1'b0);

      // R10: branch test over several flag states
      branch_sweep();
      apply(2'd3, 8'h10, 8'h20, 1'b1, 1'b0);
      branch_sweep();
      apply(2'd0, 8'h00, 8'h00, 1'b0, 1'b1);
      apply(2'd2, 8'h05, 8'h05, 1'b1, 1'b0);
      branch_sweep();

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule